// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core

This block is a small 32-bit processor that completes one instruction in every clock cycle. It fetches from, loads from and stores to a single storage array of 32-bit words. The array has two ports: a fetch port indexed by the program counter, and a load/store port indexed by the effective address. The core executes ten instructions: word load, word store, add, subtract, add-immediate, bitwise and, or and nor, signed set-less-than, and branch-if-equal. It has no jumps, no exceptions, no pipeline and no sub-word accesses.

The program image is a parameter. The array is loaded from it on every reset, so the block needs no loader port. Fixed observation outputs expose, in every cycle, the following values of the instruction being executed:

- its program counter
- its opcode
- both source register indices and the values read from them
- the destination index
- the value sent to write-back

The surrounding logic and the bench follow execution through these outputs alone.

Top module: `scalar_core`

## Requirements
- R1: While `rst_n` is low at a rising edge, the program counter and all 32 registers clear to zero and the storage array reloads from `INIT_IMAGE`. Word k of the array is `INIT_IMAGE[32k+31:32k]`.
- R2: The fetched word is array entry PC[9:2]. The PC is a byte address. After every instruction other than a taken branch, it advances by exactly 4.
- R3: Instruction fields sit at fixed positions: opcode [31:26], first source [25:21], second source/target [20:16], R-type destination [15:11], immediate [15:0], function code [5:0]. `dbg_opcode`, `dbg_rs_idx` and `dbg_rt_idx` show bits [31:26], [25:21] and [20:16].
- R4: Opcode 0x00 selects a register operation by its function code: 0x20 add, 0x22 subtract (first minus second), 0x24 and, 0x25 or, 0x27 nor. The result is written to the register at [15:11].
- R5: Function code 0x2A (opcode 0x00) writes 1 when the first source is less than the second as signed 32-bit numbers, and 0 otherwise.
- R6: Opcode 0x08 writes the first source plus the sign-extended immediate to the register at [20:16].
- R7: Opcode 0x23 forms the effective address as first source plus sign-extended immediate. It uses the low 8 bits of that sum directly as a word index, with no division by 4. It loads the addressed word into the register at [20:16].
- R8: Opcode 0x2B writes the register at [20:16] to the word at the effective address, at the clock edge. No register changes.
- R9: Opcode 0x04 compares both sources. When they are equal, the next PC is PC+4 plus the sign-extended immediate shifted left by 2. Otherwise the next PC is PC+4. No register changes.
- R10: Register 0 always reads as zero, and writes to it are discarded.
- R11: `dbg_rs_val` and `dbg_rt_val` are the register-file reads of [25:21] and [20:16]. `dbg_wr_idx` is [15:11] for opcode 0x00 and [20:16] otherwise. `dbg_wr_val` is the loaded word for opcode 0x23 and otherwise the ALU result: the effective address for 0x2B, and first minus second source for 0x04.
- R12: Fetch and load/store share one array. A word that has been stored is the word fetched when the PC later reaches it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| dbg_pc | output | 32 | Program counter of the executing instruction |
| dbg_opcode | output | 6 | Opcode field of the executing instruction |
| dbg_rs_idx | output | 5 | First source register index |
| dbg_rs_val | output | 32 | Value read for the first source |
| dbg_rt_idx | output | 5 | Second source / target register index |
| dbg_rt_val | output | 32 | Value read for the second source |
| dbg_wr_idx | output | 5 | Destination register index |
| dbg_wr_val | output | 32 | Value presented to write-back |

## Verification
The assertions assume that the program image contains only the ten supported opcodes and function codes. They also assume that every branch lands inside the 256-word array. Without these conditions, the PC-step and zero-register properties could meet states that the requirements leave undefined.

The stimulus keeps within these limits. It is one hand-encoded program that uses only the listed encodings. It runs a counted loop, mutating its operands on each pass so that the signed comparisons and logic operations see changing sign patterns. It stores a fresh instruction over a word it has not yet reached, and it ends in a branch to itself.

// File: rtl/core_pkg.sv
// core_pkg: shared encodings and control bundle for the single-cycle core.
// Assumes a 32-bit instruction word; nothing here is configurable.
package core_pkg;
    localparam int XLEN = 32;

    localparam logic [5:0] OPC_REG  = 6'h00;
    localparam logic [5:0] OPC_BEQ  = 6'h04;
    localparam logic [5:0] OPC_ADDI = 6'h08;
    localparam logic [5:0] OPC_LOAD = 6'h23;
    localparam logic [5:0] OPC_STOR = 6'h2B;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_NOR = 6'h27;
    localparam logic [5:0] FN_SLT = 6'h2A;

    localparam logic [3:0] ALU_AND = 4'd0;
    localparam logic [3:0] ALU_OR  = 4'd1;
    localparam logic [3:0] ALU_ADD = 4'd2;
    localparam logic [3:0] ALU_SUB = 4'd6;
    localparam logic [3:0] ALU_SLT = 4'd7;
    localparam logic [3:0] ALU_NOR = 4'd12;

    typedef enum logic [1:0] {
        AOP_ADD   = 2'd0,
        AOP_SUB   = 2'd1,
        AOP_FUNCT = 2'd2
    } alu_op_e;

    typedef struct packed {
        logic    dst_is_rd;
        logic    is_branch;
        logic    mem_rd;
        logic    wb_from_mem;
        alu_op_e alu_op;
        logic    mem_wr;
        logic    b_is_imm;
        logic    reg_wr;
    } ctrl_t;
endpackage

// File: rtl/core_decode.sv
// core_decode: main control from the opcode plus ALU operation selection.
// Assumes undefined opcodes act as no-ops (no writes, no branch).
module core_decode
    import core_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl,
    output logic [3:0] alu_ctrl
);
    // Main decoder: one control bundle per supported opcode.
    always_comb begin
        ctrl = '0;
        ctrl.alu_op = AOP_ADD;
        case (opcode)
            OPC_REG:  begin ctrl.dst_is_rd = 1'b1; ctrl.alu_op = AOP_FUNCT; ctrl.reg_wr = 1'b1; end
            OPC_LOAD: begin ctrl.mem_rd = 1'b1; ctrl.wb_from_mem = 1'b1; ctrl.b_is_imm = 1'b1; ctrl.reg_wr = 1'b1; end
            OPC_STOR: begin ctrl.mem_wr = 1'b1; ctrl.b_is_imm = 1'b1; end
            OPC_ADDI: begin ctrl.b_is_imm = 1'b1; ctrl.reg_wr = 1'b1; end
            OPC_BEQ:  begin ctrl.is_branch = 1'b1; ctrl.alu_op = AOP_SUB; end
            default:  ctrl = '0;
        endcase
    end

    // ALU control: fixed add/sub, or function-code lookup for register ops.
    always_comb begin
        alu_ctrl = ALU_ADD;
        case (ctrl.alu_op)
            AOP_SUB: alu_ctrl = ALU_SUB;
            AOP_FUNCT: begin
                case (funct)
                    FN_SUB:  alu_ctrl = ALU_SUB;
                    FN_AND:  alu_ctrl = ALU_AND;
                    FN_OR:   alu_ctrl = ALU_OR;
                    FN_NOR:  alu_ctrl = ALU_NOR;
                    FN_SLT:  alu_ctrl = ALU_SLT;
                    default: alu_ctrl = ALU_ADD;
                endcase
            end
            default: alu_ctrl = ALU_ADD;
        endcase
    end
endmodule

// File: rtl/core_alu.sv
// core_alu: combinational arithmetic/logic unit, also used as the two fixed adders.
// Assumes ctrl is one of the core_pkg ALU codes; others yield zero.
module core_alu
    import core_pkg::*;
#(
    parameter int XW = XLEN
) (
    input  logic [XW-1:0] a,
    input  logic [XW-1:0] b,
    input  logic [3:0]    ctrl,
    output logic [XW-1:0] y
);
    // Operation select.
    always_comb begin
        case (ctrl)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = ($signed(a) < $signed(b)) ? XW'(1) : '0;
            ALU_NOR: y = ~(a | b);
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/core_regfile.sv
// core_regfile: general registers, two combinational reads, one edge write.
// Assumes entry 0 is hard zero: its writes are dropped and its reads forced to zero.
module core_regfile #(
    parameter int REG_N = 32,
    parameter int XW    = 32,
    localparam int IDX_W = $clog2(REG_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] ra1,
    input  logic [IDX_W-1:0] ra2,
    output logic [XW-1:0]    rd1,
    output logic [XW-1:0]    rd2,
    input  logic             we,
    input  logic [IDX_W-1:0] wa,
    input  logic [XW-1:0]    wd
);
    logic [XW-1:0] regs_q [REG_N];

    // Clear on reset, otherwise write one non-zero entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < REG_N; i++) regs_q[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs_q[wa] <= wd;
        end
    end

    // Read ports with the zero-register guard.
    assign rd1 = (ra1 == '0) ? '0 : regs_q[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs_q[ra2];
endmodule

// File: rtl/core_mem.sv
// core_mem: word array with an asynchronous fetch port and a load/store port.
// Assumes the program image arrives as a parameter and is reloaded on reset.
module core_mem #(
    parameter int XW     = 32,
    parameter int ADDR_W = 8,
    localparam int DEPTH = 1 << ADDR_W,
    parameter logic [XW*DEPTH-1:0] IMAGE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] fetch_idx,
    output logic [XW-1:0]     fetch_word,
    input  logic [ADDR_W-1:0] data_idx,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [XW-1:0]     wdata,
    output logic [XW-1:0]     rdata
);
    logic [XW-1:0] words_q [DEPTH];

    // Image load on reset, otherwise store on the edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) words_q[i] <= IMAGE[i*XW +: XW];
        end else if (wr_en) begin
            words_q[data_idx] <= wdata;
        end
    end

    // Combinational reads; the load port is gated by its enable.
    assign fetch_word = words_q[fetch_idx];
    assign rdata      = rd_en ? words_q[data_idx] : '0;
endmodule

// File: rtl/scalar_core.sv
// scalar_core: single-cycle core; PC register, fixed adders, decode, regfile, ALU, memory.
// Assumes the image holds only supported encodings and branches stay inside the array.
module scalar_core
    import core_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [(XLEN << ADDR_W)-1:0] INIT_IMAGE = '0
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [31:0] dbg_pc,
    output logic [5:0]  dbg_opcode,
    output logic [4:0]  dbg_rs_idx,
    output logic [31:0] dbg_rs_val,
    output logic [4:0]  dbg_rt_idx,
    output logic [31:0] dbg_rt_val,
    output logic [4:0]  dbg_wr_idx,
    output logic [31:0] dbg_wr_val
);
    localparam int REG_N = 32;

    logic [XLEN-1:0] pc_q, pc_plus4, br_target, pc_next;
    logic [XLEN-1:0] instr, imm_sext, rs_val, rt_val, alu_b, alu_y, load_word, wb_val;
    logic [4:0]      wr_idx;
    logic            alu_zero;
    ctrl_t           ctrl;
    logic [3:0]      alu_ctrl;

    // Program counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_next;
    end

    core_alu #(.XW(XLEN)) u_pc_add (
        .a(pc_q), .b(XLEN'(4)), .ctrl(ALU_ADD), .y(pc_plus4)
    );

    core_alu #(.XW(XLEN)) u_br_add (
        .a(pc_plus4), .b({imm_sext[XLEN-3:0], 2'b00}), .ctrl(ALU_ADD), .y(br_target)
    );

    core_decode u_dec (
        .opcode(instr[31:26]), .funct(instr[5:0]), .ctrl(ctrl), .alu_ctrl(alu_ctrl)
    );

    core_regfile #(.REG_N(REG_N), .XW(XLEN)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .ra1(instr[25:21]), .ra2(instr[20:16]),
        .rd1(rs_val), .rd2(rt_val),
        .we(ctrl.reg_wr), .wa(wr_idx), .wd(wb_val)
    );

    core_alu #(.XW(XLEN)) u_alu (
        .a(rs_val), .b(alu_b), .ctrl(alu_ctrl), .y(alu_y)
    );

    core_mem #(.XW(XLEN), .ADDR_W(ADDR_W), .IMAGE(INIT_IMAGE)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .fetch_idx(pc_q[ADDR_W+1:2]), .fetch_word(instr),
        .data_idx(alu_y[ADDR_W-1:0]),
        .wr_en(ctrl.mem_wr), .rd_en(ctrl.mem_rd),
        .wdata(rt_val), .rdata(load_word)
    );

    // Datapath muxes, branch decision and next-PC select.
    always_comb begin
        imm_sext = {{(XLEN-16){instr[15]}}, instr[15:0]};
        alu_b    = ctrl.b_is_imm ? imm_sext : rt_val;
        wr_idx   = ctrl.dst_is_rd ? instr[15:11] : instr[20:16];
        wb_val   = ctrl.wb_from_mem ? load_word : alu_y;
        alu_zero = (alu_y == '0);
        pc_next  = (ctrl.is_branch && alu_zero) ? br_target : pc_plus4;
    end

    // Observation taps.
    assign dbg_pc     = pc_q;
    assign dbg_opcode = instr[31:26];
    assign dbg_rs_idx = instr[25:21];
    assign dbg_rs_val = rs_val;
    assign dbg_rt_idx = instr[20:16];
    assign dbg_rt_val = rt_val;
    assign dbg_wr_idx = wr_idx;
    assign dbg_wr_val = wb_val;
endmodule

// File: rtl/core_checker.sv
// core_checker: temporal properties of scalar_core, attached by bind.
// Assumes a program of supported encodings only.
module core_checker
    import core_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] instr,
    input logic [31:0] dbg_pc,
    input logic [5:0]  dbg_opcode,
    input logic [4:0]  dbg_rs_idx,
    input logic [31:0] dbg_rs_val,
    input logic [4:0]  dbg_rt_idx,
    input logic [31:0] dbg_rt_val,
    input logic [31:0] dbg_wr_val
);
    logic [31:0] br_off;
    assign br_off = {{14{instr[15]}}, instr[15:0], 2'b00};

    assert_reset_pc_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> dbg_pc == 32'd0);

    assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_opcode != OPC_BEQ || dbg_rs_val != dbg_rt_val) |=> dbg_pc == $past(dbg_pc) + 32'd4);

    assert_branch_taken_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_opcode == OPC_BEQ && dbg_rs_val == dbg_rt_val) |=>
            dbg_pc == $past(dbg_pc) + 32'd4 + $past(br_off));

    assert_zero_rs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_rs_idx == 5'd0 |-> dbg_rs_val == 32'd0);

    assert_zero_rt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_rt_idx == 5'd0 |-> dbg_rt_val == 32'd0);

    assert_slt_bool_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_opcode == OPC_REG && instr[5:0] == FN_SLT) |-> dbg_wr_val[31:1] == 31'd0);
endmodule

bind scalar_core core_checker u_chk (
    .clk(clk), .rst_n(rst_n), .instr(instr),
    .dbg_pc(dbg_pc), .dbg_opcode(dbg_opcode),
    .dbg_rs_idx(dbg_rs_idx), .dbg_rs_val(dbg_rs_val),
    .dbg_rt_idx(dbg_rt_idx), .dbg_rt_val(dbg_rt_val),
    .dbg_wr_val(dbg_wr_val)
);

// File: tb/tb_scalar_core.sv
// tb_scalar_core: runs a hand-encoded program and compares every cycle's taps
// against an instruction-level model kept in the bench.
module tb_scalar_core;
    localparam int AW = 8;
    localparam int NW = 1 << AW;

    function automatic logic [31:0] enc_r(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd, logic [5:0] fn);
        return {6'h00, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [32*NW-1:0] build_image();
        logic [32*NW-1:0] img;
        img = '0;
        img[0*32 +: 32]  = enc_i(6'h23, 5'd0, 5'd2, 16'd31);
        img[1*32 +: 32]  = enc_i(6'h23, 5'd0, 5'd3, 16'd32);
        img[2*32 +: 32]  = enc_i(6'h08, 5'd0, 5'd14, 16'd24);
        img[3*32 +: 32]  = enc_r(5'd2, 5'd3, 5'd4, 6'h20);
        img[4*32 +: 32]  = enc_r(5'd2, 5'd3, 5'd5, 6'h22);
        img[5*32 +: 32]  = enc_r(5'd2, 5'd3, 5'd6, 6'h24);
        img[6*32 +: 32]  = enc_r(5'd2, 5'd3, 5'd7, 6'h25);
        img[7*32 +: 32]  = enc_r(5'd2, 5'd3, 5'd8, 6'h27);
        img[8*32 +: 32]  = enc_r(5'd2, 5'd3, 5'd9, 6'h2A);
        img[9*32 +: 32]  = enc_r(5'd3, 5'd2, 5'd10, 6'h2A);
        img[10*32 +: 32] = enc_i(6'h08, 5'd2, 5'd11, 16'hFFB3);
        img[11*32 +: 32] = enc_i(6'h2B, 5'd0, 5'd4, 16'd33);
        img[12*32 +: 32] = enc_i(6'h23, 5'd0, 5'd12, 16'd33);
        img[13*32 +: 32] = enc_i(6'h08, 5'd5, 5'd0, 16'd9);
        img[14*32 +: 32] = enc_r(5'd0, 5'd12, 5'd13, 6'h20);
        img[15*32 +: 32] = enc_i(6'h04, 5'd9, 5'd10, 16'd1);
        img[16*32 +: 32] = enc_i(6'h08, 5'd15, 5'd15, 16'd1);
        img[17*32 +: 32] = enc_i(6'h08, 5'd1, 5'd1, 16'd1);
        img[18*32 +: 32] = enc_r(5'd4, 5'd11, 5'd16, 6'h20);
        img[19*32 +: 32] = enc_r(5'd16, 5'd6, 5'd3, 6'h27);
        img[20*32 +: 32] = enc_r(5'd16, 5'd10, 5'd2, 6'h20);
        img[21*32 +: 32] = enc_i(6'h04, 5'd1, 5'd14, 16'd1);
        img[22*32 +: 32] = enc_i(6'h04, 5'd0, 5'd0, 16'hFFEC);
        img[23*32 +: 32] = enc_i(6'h23, 5'd0, 5'd17, 16'd34);
        img[24*32 +: 32] = enc_i(6'h2B, 5'd0, 5'd17, 16'd26);
        img[25*32 +: 32] = enc_i(6'h04, 5'd0, 5'd0, 16'd0);
        img[26*32 +: 32] = enc_r(5'd0, 5'd0, 5'd19, 6'h20);
        img[27*32 +: 32] = enc_i(6'h04, 5'd0, 5'd0, 16'hFFFF);
        img[31*32 +: 32] = 32'h0000_0056;
        img[32*32 +: 32] = 32'hFFFF_FF80;
        img[34*32 +: 32] = enc_i(6'h08, 5'd0, 5'd18, 16'h0055);
        return img;
    endfunction

    localparam logic [32*NW-1:0] IMAGE = build_image();

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [31:0] dbg_pc, dbg_rs_val, dbg_rt_val, dbg_wr_val;
    logic [5:0]  dbg_opcode;
    logic [4:0]  dbg_rs_idx, dbg_rt_idx, dbg_wr_idx;

    always #5 clk = ~clk;

    scalar_core #(.ADDR_W(AW), .INIT_IMAGE(IMAGE)) dut (
        .clk(clk), .rst_n(rst_n),
        .dbg_pc(dbg_pc), .dbg_opcode(dbg_opcode),
        .dbg_rs_idx(dbg_rs_idx), .dbg_rs_val(dbg_rs_val),
        .dbg_rt_idx(dbg_rt_idx), .dbg_rt_val(dbg_rt_val),
        .dbg_wr_idx(dbg_wr_idx), .dbg_wr_val(dbg_wr_val)
    );

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [31:0] rm_mem [NW];
    logic [31:0] rm_reg [32];
    logic [31:0] rm_pc;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h (model pc=%0d)", tag, act, exp, rm_pc);
        end
    endtask

    // Compare this cycle's taps against the model, then retire the instruction in the model.
    task automatic model_step();
        logic [31:0] ins, a, b, imm, res, ea;
        logic [4:0]  widx;
        logic        we, taken;
        ins   = rm_mem[rm_pc[AW+1:2]];
        a     = rm_reg[ins[25:21]];
        b     = rm_reg[ins[20:16]];
        imm   = {{16{ins[15]}}, ins[15:0]};
        ea    = a + imm;
        widx  = ins[20:16];
        we    = 1'b0;
        taken = 1'b0;
        res   = 32'd0;
        case (ins[31:26])
            6'h00: begin
                widx = ins[15:11];
                we   = 1'b1;
                case (ins[5:0])
                    6'h20: res = a + b;
                    6'h22: res = a - b;
                    6'h24: res = a & b;
                    6'h25: res = a | b;
                    6'h27: res = ~(a | b);
                    6'h2A: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                    default: res = 32'd0;
                endcase
            end
            6'h08: begin res = ea; we = 1'b1; end
            6'h23: begin res = rm_mem[ea[AW-1:0]]; we = 1'b1; end
            6'h2B: res = ea;
            6'h04: begin res = a - b; taken = (a == b); end
            default: res = 32'd0;
        endcase
        chk("R2 pc", dbg_pc, rm_pc);
        chk("R3 opcode", {26'd0, dbg_opcode}, {26'd0, ins[31:26]});
        chk("R3 rs index", {27'd0, dbg_rs_idx}, {27'd0, ins[25:21]});
        chk("R3 rt index", {27'd0, dbg_rt_idx}, {27'd0, ins[20:16]});
        chk("R11 rs value", dbg_rs_val, a);
        chk("R11 rt value", dbg_rt_val, b);
        chk("R11 dest index", {27'd0, dbg_wr_idx}, {27'd0, widx});
        case (ins[31:26])
            6'h00:   chk((ins[5:0] == 6'h2A) ? "R5 slt result" : "R4 reg op result", dbg_wr_val, res);
            6'h08:   chk("R6 addi result", dbg_wr_val, res);
            6'h23:   chk("R7 load data", dbg_wr_val, res);
            6'h2B:   chk("R8 store address", dbg_wr_val, res);
            default: chk("R9 compare diff", dbg_wr_val, res);
        endcase
        if (ins[31:26] == 6'h2B) rm_mem[ea[AW-1:0]] = b;
        if (we && widx != 5'd0) rm_reg[widx] = res;
        rm_pc = taken ? rm_pc + 32'd4 + {imm[29:0], 2'b00} : rm_pc + 32'd4;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // Main sequence: reset, then step the program with per-cycle comparison.
    initial begin
        for (int i = 0; i < NW; i++) rm_mem[i] = IMAGE[i*32 +: 32];
        for (int i = 0; i < 32; i++) rm_reg[i] = 32'd0;
        rm_pc = 32'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset pc", dbg_pc, 32'd0);
        chk("R1 reset opcode from image", {26'd0, dbg_opcode}, 32'h23);
        chk("R1 reset reg read", dbg_rt_val, 32'd0);
        rst_n = 1'b1;
        for (int cyc = 0; cyc < 800; cyc++) begin
            if (cyc == 0) chk("R7 first load word 31", dbg_wr_val, 32'h56);
            if (rm_pc == 32'd52) chk("R10 write to r0 index", {27'd0, dbg_wr_idx}, 32'd0);
            if (rm_pc == 32'd56) chk("R10 r0 reads zero", dbg_rs_val, 32'd0);
            if (rm_pc == 32'd104) begin
                chk("R12 patched opcode", {26'd0, dbg_opcode}, 32'h08);
                chk("R12 patched result", dbg_wr_val, 32'h55);
            end
            model_step();
            @(negedge clk);
        end
        chk("R9 final self-loop pc", dbg_pc, 32'd108);
        chk("R9 model reached halt", rm_pc, 32'd108);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule